// File: doc/BRIEF.md
# Guarded Sequence Table

This block holds the instruction words that a serial-memory sequence engine executes. The storage is 64 words of 32 bits, grouped as 16 slots of four words each. A simple register bus reads and writes the table. A separate combinational port lets the engine fetch any word by slot and word number.

Stored sequences are protected from stray writes. The table comes out of reset locked, and any write to it is dropped while it is locked. Changing the lock state takes two steps. First, a fixed 32-bit key goes to the key register. Then, as the very next bus access, a lock or unlock command goes to the lock-control register.

Slot 0 is preset at reset with a default sequence, so the engine can run a basic operation straight away. Software normally reprograms a different slot. The usual sequence is: key, unlock, table words, key, lock.

Top module: `seqtab_guard`

## Requirements
- R1: After reset the table is locked and a read of the lock-control register returns 1 in bit 0. Slot 0 words 0 to 3 hold 0x08180403, 0x24001C08, 0x00000000 and 0x00000000. Every other word holds zero.
- R2: Writing 0x5AF05AF0 to address 0x300 arms the guard. Only while armed does a write to 0x304 take effect: wdata bits [1:0] = 01 locks the table and 10 unlocks it. Without arming, a write to 0x304 leaves the lock state unchanged. A repeated correct key write keeps the guard armed.
- R3: Any bus access between the key write and the command disarms the guard, so the command is then ignored. This covers a read of any address, a write of any other value or address, and a key write with a wrong value.
- R4: A lock-control write whose bits [1:0] are 11 or 00 leaves the lock state unchanged and still disarms the guard.
- R5: Table word `w` of slot `s` lives at byte address 0x310 + 16*s + 4*w. A write there is stored while the table is unlocked and silently dropped while it is locked.
- R6: A read returns its data on `rdata` one cycle after `rd_en`, and `rdata` holds its value otherwise. The data is:
  - the stored word for a table address, whether locked or not;
  - {31'b0, locked} for 0x304;
  - zero for the key register;
  - zero for any unmapped address.
  Writes to unmapped addresses change nothing. When `wr_en` and `rd_en` are both high, only the write is performed.
- R7: `eng_data` shows the word selected by `eng_slot` and `eng_word` without delay. It reflects a table write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| eng_slot | input | 4 | Engine slot select |
| eng_word | input | 2 | Engine word select within slot |
| eng_data | output | 32 | Engine read word |

## Verification
The hardest case to reach is an arming that is broken by an intervening access. The command has to land exactly one access after the key, and the disturbing access has to be a read, a wrong key or a command with both bits or neither bit set. The stimulus builds these back-to-back sequences explicitly. After each one it reads the lock-control register and attempts a table write, which shows whether the guard really stayed shut. The engine port is swept across all 64 words during the whole run, so each table write is also seen from the engine side.

// File: rtl/seqtab_guard.sv
module seqtab_guard #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int SLOTS = 16,
  parameter int WPS = 4,
  parameter logic [DW-1:0] KEY = 32'h5AF0_5AF0,
  parameter logic [AW-1:0] KEY_OFF = 12'h300,
  parameter logic [AW-1:0] CTRL_OFF = 12'h304,
  parameter logic [AW-1:0] TAB_OFF = 12'h310,
  parameter int PRESET_SLOT = 0,
  parameter logic [DW-1:0] PRE0 = 32'h0818_0403,
  parameter logic [DW-1:0] PRE1 = 32'h2400_1C08,
  parameter logic [DW-1:0] PRE2 = 32'h0000_0000,
  parameter logic [DW-1:0] PRE3 = 32'h0000_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  input  logic [$clog2(SLOTS)-1:0] eng_slot,
  input  logic [$clog2(WPS)-1:0]   eng_word,
  output logic [DW-1:0]            eng_data
);
  localparam int DEPTH = SLOTS * WPS;
  localparam int IW = $clog2(DEPTH);
  localparam logic [AW:0] TAB_END = (AW+1)'(TAB_OFF) + (AW+1)'(DEPTH * 4);

  logic [DW-1:0] mem [DEPTH];
  logic locked, armed;

  wire hit_key  = (addr == KEY_OFF);
  wire hit_ctrl = (addr == CTRL_OFF);
  wire hit_tab  = (addr >= TAB_OFF) && ({1'b0, addr} < TAB_END);
  wire [IW-1:0] idx = IW'((addr - TAB_OFF) >> 2);
  wire tab_wr = wr_en && hit_tab && !locked;

  function automatic logic [DW-1:0] preset_of(int i);
    if (i / WPS != PRESET_SLOT) return '0;
    case (i % WPS)
      0: return PRE0;
      1: return PRE1;
      2: return PRE2;
      3: return PRE3;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      locked <= 1'b1;
    end else if (wr_en || rd_en) begin
      armed <= wr_en && hit_key && (wdata == KEY);
      if (wr_en && hit_ctrl && armed) begin
        case (wdata[1:0])
          2'b01:   locked <= 1'b1;
          2'b10:   locked <= 1'b0;
          default: locked <= locked;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= preset_of(i);
    end else if (tab_wr) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en && !wr_en)
      rdata <= hit_tab  ? mem[idx] :
               hit_ctrl ? {{(DW-1){1'b0}}, locked} : '0;
  end

  assign eng_data = mem[IW'(eng_slot * WPS + eng_word)];

  assert_cmd_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked) |-> $past(wr_en && hit_ctrl && armed));
  assert_arm_from_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && hit_key && wdata == KEY));
  assert_any_access_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || (wr_en && !hit_key)) |=> !armed);
  assert_both_or_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ctrl && (wdata[1] == wdata[0])) |=> $stable(locked));
  assert_locked_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_tab && locked) |=> mem[$past(idx)] == $past(mem[idx]));
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rdata));
endmodule

// File: tb/sim_seqtab_guard.sv
module sim_seqtab_guard;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata, eng_data;
  logic [3:0] eng_slot = 0;
  logic [1:0] eng_word = 0;

  seqtab_guard u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .eng_slot(eng_slot),
    .eng_word(eng_word), .eng_data(eng_data));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, eng_i = 0;
  bit done = 0;
  logic [31:0] m_mem [64];
  bit m_locked, m_armed;
  logic [31:0] m_rdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = 0;
    m_mem[0] = 32'h0818_0403;
    m_mem[1] = 32'h2400_1C08;
    m_locked = 1; m_armed = 0; m_rdata = 0;
  endtask

  task automatic op(bit we, bit re, int a, logic [31:0] d, string tag);
    bit tab;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = 12'(a); wdata = d;
    eng_slot = 4'(eng_i / 4); eng_word = 2'(eng_i % 4);
    @(posedge clk);
    tab = (a >= 'h310) && (a < 'h410);
    if (re && !we)
      m_rdata = tab ? m_mem[(a - 'h310) / 4] : (a == 'h304) ? {31'b0, m_locked} : 0;
    if (we && tab && !m_locked) m_mem[(a - 'h310) / 4] = d;
    if (we && a == 'h304 && m_armed) begin
      if (d[1:0] == 2'b01) m_locked = 1;
      else if (d[1:0] == 2'b10) m_locked = 0;
    end
    if (we || re) m_armed = we && a == 'h300 && d == 32'h5AF0_5AF0;
    @(negedge clk);
    chk(tag, rdata, m_rdata);
    chk("R7", eng_data, m_mem[eng_i]);
    eng_i = (eng_i + 1) % 64;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(int a, logic [31:0] d, string tag); op(1, 0, a, d, tag); endtask
  task automatic rd(int a, string tag); op(0, 1, a, 0, tag); endtask
  task automatic key(); wr('h300, 32'h5AF0_5AF0, "R2"); endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd('h304, "R1");
    chk("R1", rdata, 32'h1);
    for (int w = 0; w < 4; w++) rd('h310 + 4*w, "R1");
    rd('h400, "R1");
    // R5 locked write dropped
    wr('h400, 32'hDEAD_BEEF, "R5");
    rd('h400, "R5");
    // R2 unlock without key
    wr('h304, 2, "R2");
    rd('h304, "R2");
    // R3 read between key and command
    key(); rd('h310, "R3"); wr('h304, 2, "R3");
    rd('h304, "R3");
    // R3 wrong key, then other-address write
    wr('h300, 32'h5AF0_5AF1, "R3"); wr('h304, 2, "R3"); rd('h304, "R3");
    key(); wr('h500, 32'h1, "R3"); wr('h304, 2, "R3"); rd('h304, "R3");
    // R2 proper unlock
    key(); wr('h304, 2, "R2");
    rd('h304, "R2");
    chk("R2", rdata, 32'h0);
    // R5 program slot 15 and slot 3
    for (int w = 0; w < 4; w++) wr('h400 + 4*w, 32'hA5A5_0000 + w, "R5");
    wr('h310 + 16*3 + 8, 32'h1234_5678, "R5");
    for (int w = 0; w < 4; w++) rd('h400 + 4*w, "R5");
    rd('h310 + 16*3 + 8, "R5");
    // R4 both bits / no bits, and consumed arming
    key(); wr('h304, 3, "R4"); rd('h304, "R4");
    key(); wr('h304, 0, "R4"); wr('h304, 1, "R4"); rd('h304, "R4");
    chk("R4", rdata, 32'h0);
    // R2 double key then lock
    key(); key(); wr('h304, 1, "R2"); rd('h304, "R2");
    chk("R2", rdata, 32'h1);
    wr('h404, 32'hFFFF_FFFF, "R5"); rd('h404, "R5");
    // R6 key reg and unmapped reads, simultaneous strobes
    rd('h300, "R6"); rd('h0, "R6"); rd('h410, "R6");
    op(1, 1, 'h400, 32'h0, "R6");
    // R7 engine sweep over all words
    for (int k = 0; k < 70; k++) rd('h304, "R7");
    // reset restores state
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    model_reset();
    rd('h400, "R1"); rd('h310, "R1");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule